// File: doc/BRIEF.md
# Root Hub Port Status and Control

This block holds the software-visible state of a single downstream port on a host controller's root hub. It samples the line-state indications from the port transceiver: device present, low-speed device, resume seen and fault. From them it keeps the connect, enable, reset and suspend state and two sticky change flags. All of this is exposed through one 16-bit status/control word, which the host's register decoder writes with a one-cycle strobe. The block drives reset signalling and suspend controls back toward the transceiver.

Software can only turn the port on. Hardware can only turn it off: a disconnect or a fault clears the enable bit on its own. Change flags stay set until software writes a one to their position. Reading the word has no side effects, and the read value is combinational from the held state. Timing the length of the reset pulse is left to software or to logic outside this block.

Top module: `rhp_port_ctl`

## Requirements
- R1: After reset every bit of the status word reads 0, and `drv_reset` and `drv_suspend` are low.
- R2: Bit 0 (connect) equals `dev_present` as sampled at the most recent clock edge.
- R3: Bit 1 (connect change) is set at any edge where the sampled connect state changes. It is cleared by a write with bit 1 = 1, and a write with bit 1 = 0 leaves it alone. When a new change and a clearing write land on the same edge, the flag stays set.
- R4: Bit 2 (enable) becomes 1 only through a write with bit 2 = 1. A write with bit 2 = 0 clears it.
- R5: A disconnect (bit 0 going from 1 to 0) while the port is enabled clears bit 2 and sets bit 3 (enable change). Bit 3 is cleared only by a write with bit 3 = 1.
- R6: A cycle with `port_fault` high clears bit 2 at the next edge and does not set bit 3.
- R7: Bit 6 (resume) equals `resume_seen` as sampled at the most recent edge. Writes to it have no effect.
- R8: Bit 8 (low speed) equals `dev_lowspeed` as sampled at the most recent edge. Writes to it have no effect.
- R9: Bit 9 (port reset) is read/write, and `drv_reset` follows it. While bit 9 is set, and on the write that sets it, bit 2 is forced to 0 and writes of 1 to bit 2 are ignored. Clearing bit 9 leaves the port disabled.
- R10: Bit 12 (suspend) is read/write, and `drv_suspend` follows it. A write with bit 12 = 1 while `global_susp` is high leaves the bit unchanged. A write of 0 always clears it.
- R11: Bits 4, 5, 7, 10, 11, 13, 14 and 15 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | One-cycle write strobe for the status word |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Current status word |
| dev_present | input | 1 | Transceiver sees a device attached |
| dev_lowspeed | input | 1 | Attached device is low speed |
| resume_seen | input | 1 | Resume signalling detected or driven on the line |
| port_fault | input | 1 | Port fault condition |
| global_susp | input | 1 | Controller is in global suspend |
| drv_reset | output | 1 | Drive reset signalling on the port |
| drv_suspend | output | 1 | Hold the port in suspend |

## Verification
Every piece of state is one register deep, so a wrong internal value shows up in `reg_rdata` or on a drive pin one clock after the stimulus that caused it. A missed or early clear of a change flag stays visible until the next write-one. That makes it detectable at the very next read. An enable bit that hardware wrongly sets, or fails to clear, also shows up on the next read, because only one edge separates a write, a disconnect or a fault from its effect.

// File: rtl/rhp_pkg.sv
package rhp_pkg;
  localparam int REG_W  = 16;
  localparam int B_CONN = 0;
  localparam int B_CSC  = 1;
  localparam int B_EN   = 2;
  localparam int B_ENC  = 3;
  localparam int B_RSM  = 6;
  localparam int B_LS   = 8;
  localparam int B_RST  = 9;
  localparam int B_SUSP = 12;
  localparam int NFLAG  = 2;

  function automatic logic [REG_W-1:0] defined_mask();
    logic [REG_W-1:0] m;
    m = '0;
    m[B_CONN] = 1'b1; m[B_CSC] = 1'b1; m[B_EN] = 1'b1; m[B_ENC] = 1'b1;
    m[B_RSM]  = 1'b1; m[B_LS]  = 1'b1; m[B_RST] = 1'b1; m[B_SUSP] = 1'b1;
    return m;
  endfunction

  localparam logic [REG_W-1:0] DEF_MASK = defined_mask();

  typedef struct packed {
    logic conn;
    logic ls;
    logic rsm;
    logic conn_chg;
    logic disc;
  } line_t;
endpackage

// File: rtl/rhp_line_sample.sv
module rhp_line_sample
  import rhp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  dev_present,
  input  logic  dev_lowspeed,
  input  logic  resume_seen,
  output line_t line_o
);
  logic conn_q, ls_q, rsm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conn_q <= 1'b0;
      ls_q   <= 1'b0;
      rsm_q  <= 1'b0;
    end else begin
      conn_q <= dev_present;
      ls_q   <= dev_lowspeed;
      rsm_q  <= resume_seen;
    end
  end

  always_comb begin
    line_o.conn     = conn_q;
    line_o.ls       = ls_q;
    line_o.rsm      = rsm_q;
    line_o.conn_chg = dev_present ^ conn_q;
    line_o.disc     = conn_q & ~dev_present;
  end
endmodule

// File: rtl/rhp_w1c_flag.sv
module rhp_w1c_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/rhp_port_state.sv
module rhp_port_state
  import rhp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             disc,
  input  logic             fault,
  input  logic             global_susp,
  output logic             en_o,
  output logic             rst_o,
  output logic             susp_o,
  output logic             en_lost_o
);
  logic hw_off;

  assign hw_off    = rst_o | (wr_en & wdata[B_RST]) | fault | disc;
  assign en_lost_o = en_o & disc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_o   <= 1'b0;
      rst_o  <= 1'b0;
      susp_o <= 1'b0;
    end else begin
      if (hw_off)     en_o <= 1'b0;
      else if (wr_en) en_o <= wdata[B_EN];
      if (wr_en) begin
        rst_o <= wdata[B_RST];
        if (!(wdata[B_SUSP] && global_susp)) susp_o <= wdata[B_SUSP];
      end
    end
  end
endmodule

// File: rtl/rhp_port_ctl.sv
module rhp_port_ctl
  import rhp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             dev_present,
  input  logic             dev_lowspeed,
  input  logic             resume_seen,
  input  logic             port_fault,
  input  logic             global_susp,
  output logic             drv_reset,
  output logic             drv_suspend
);
  localparam int FLAG_POS [NFLAG] = '{B_CSC, B_ENC};

  line_t            line;
  logic             en, rst_bit, susp, en_lost;
  logic [NFLAG-1:0] flag_set, flag_q;

  rhp_line_sample u_line (
    .clk(clk), .rst_n(rst_n), .dev_present(dev_present),
    .dev_lowspeed(dev_lowspeed), .resume_seen(resume_seen), .line_o(line)
  );

  rhp_port_state u_state (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wdata(reg_wdata),
    .disc(line.disc), .fault(port_fault), .global_susp(global_susp),
    .en_o(en), .rst_o(rst_bit), .susp_o(susp), .en_lost_o(en_lost)
  );

  assign flag_set = {en_lost, line.conn_chg};

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    rhp_w1c_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set_i(flag_set[g]),
      .clr_i(reg_wr & reg_wdata[FLAG_POS[g]]), .flag_o(flag_q[g])
    );
  end

  always_comb begin
    reg_rdata                 = '0;
    reg_rdata[B_CONN]         = line.conn;
    reg_rdata[B_EN]           = en;
    reg_rdata[B_RSM]          = line.rsm;
    reg_rdata[B_LS]           = line.ls;
    reg_rdata[B_RST]          = rst_bit;
    reg_rdata[B_SUSP]         = susp;
    for (int i = 0; i < NFLAG; i++) reg_rdata[FLAG_POS[i]] = flag_q[i];
  end

  assign drv_reset   = rst_bit;
  assign drv_suspend = susp;
endmodule

// File: rtl/rhp_port_chk.sv
module rhp_port_chk
  import rhp_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [REG_W-1:0] reg_wdata,
  input logic [REG_W-1:0] reg_rdata,
  input logic             dev_lowspeed,
  input logic             port_fault,
  input logic             global_susp
);
  AST_CHANGE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_rdata[B_CONN]) |-> reg_rdata[B_CSC]); // R3
  AST_ENABLE_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_rdata[B_EN]) |-> $past(reg_wr && reg_wdata[B_EN])); // R4
  AST_DISC_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(reg_rdata[B_CONN]) && $past(reg_rdata[B_EN])) |-> (reg_rdata[B_ENC] && !reg_rdata[B_EN])); // R5
  AST_FAULT_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    port_fault |=> !reg_rdata[B_EN]); // R6
  AST_LS_FROM_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_rdata[B_LS]) |-> $past(dev_lowspeed)); // R8
  AST_RESET_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[B_RST] |=> !reg_rdata[B_EN]); // R9
  AST_SUSP_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata[B_SUSP] && global_susp && !reg_rdata[B_SUSP]) |=> !reg_rdata[B_SUSP]); // R10
  AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~DEF_MASK) == '0); // R11
endmodule

bind rhp_port_ctl rhp_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .dev_lowspeed(dev_lowspeed),
  .port_fault(port_fault), .global_susp(global_susp)
);

// File: tb/sim_rhp_port_ctl.sv
module sim_rhp_port_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        dev_present = 1'b0, dev_lowspeed = 1'b0, resume_seen = 1'b0;
  logic        port_fault = 1'b0, global_susp = 1'b0;
  logic        drv_reset, drv_suspend;
  int          errors = 0, checks = 0;

  always #10 clk = ~clk;

  rhp_port_ctl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .dev_present(dev_present), .dev_lowspeed(dev_lowspeed),
    .resume_seen(resume_seen), .port_fault(port_fault), .global_susp(global_susp),
    .drv_reset(drv_reset), .drv_suspend(drv_suspend)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    #3_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R1 word", reg_rdata, 16'h0000);
    chk("R1 drive", {drv_reset, drv_suspend}, 2'b00);

    dev_present = 1'b1; dev_lowspeed = 1'b1; tick();
    chk("R2 R3 R8 attach", reg_rdata, 16'h0103);
    wr(16'h0000);
    chk("R3 R8 write zero", reg_rdata, 16'h0103);
    wr(16'h0100);
    chk("R8 ls read-only", reg_rdata, 16'h0103);
    wr(16'h0002);
    chk("R3 w1c", reg_rdata, 16'h0101);

    resume_seen = 1'b1; tick();
    chk("R7 resume", reg_rdata, 16'h0141);
    wr(16'h0040);
    chk("R7 write ignored", reg_rdata, 16'h0141);
    resume_seen = 1'b0; tick();
    chk("R7 resume gone", reg_rdata, 16'h0101);

    wr(16'h0004);
    chk("R4 enable", reg_rdata, 16'h0105);
    port_fault = 1'b1; tick(); port_fault = 1'b0;
    chk("R6 fault", reg_rdata, 16'h0101);

    wr(16'h0004);
    dev_present = 1'b0; dev_lowspeed = 1'b0; tick();
    chk("R5 R3 disconnect", reg_rdata, 16'h000A);
    wr(16'h0008);
    chk("R5 w1c", reg_rdata, 16'h0002);
    wr(16'h0002);
    chk("R3 clear", reg_rdata, 16'h0000);

    @(negedge clk); reg_wr = 1'b1; reg_wdata = 16'h0002; dev_present = 1'b1;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
    chk("R3 set wins", reg_rdata, 16'h0003);
    wr(16'h0002);

    wr(16'h0204);
    chk("R9 reset set", reg_rdata, 16'h0201);
    chk("R9 drv_reset", drv_reset, 1'b1);
    wr(16'h0204);
    chk("R9 enable blocked", reg_rdata, 16'h0201);
    wr(16'h0000);
    chk("R9 stays disabled", reg_rdata, 16'h0001);
    wr(16'h0004);
    chk("R4 enable after reset", reg_rdata, 16'h0005);

    wr(16'h1004);
    chk("R10 suspend", reg_rdata, 16'h1005);
    chk("R10 drv_suspend", drv_suspend, 1'b1);
    global_susp = 1'b1;
    wr(16'h0004);
    chk("R10 clear", reg_rdata, 16'h0005);
    wr(16'h1004);
    chk("R10 blocked", reg_rdata, 16'h0005);

    for (int gs = 0; gs < 2; gs++) begin
      global_susp = gs[0];
      for (int i = 0; i < 256; i++) begin
        logic [15:0] d, e;
        logic [7:0]  b;
        b = i[7:0];
        d = '0;
        d[1] = b[0]; d[2] = b[1]; d[3] = b[2]; d[6] = b[3];
        d[8] = b[4]; d[9] = b[5]; d[12] = b[6]; d[15] = b[7];
        wr(16'h000A);
        wr(d);
        e = 16'h0001;
        e[2]  = d[2] & ~d[9];
        e[9]  = d[9];
        e[12] = d[12] & ~gs[0];
        chk("R11 R4 R9 R10 sweep", reg_rdata, e);
        chk("R9 R10 sweep drives", {drv_reset, drv_suspend}, {e[9], e[12]});
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule